// File: doc/BRIEF.md
# Byte-Stuffed Command Frame Parser

This block sits behind a UART byte receiver and watches a stream of bytes, each qualified by a one-cycle valid strobe. It looks for framed messages that open with 0x02 and close with 0x03. It undoes the byte-stuffing inside the body and counts how many payload bytes it has restored.

When the closing byte arrives, the payload length alone sets the kind of frame. With two or more bytes the frame is bulk pattern data, written in arrival order to an on-chip RAM from address 0. With exactly one byte it is a control command and becomes a one-cycle start, stop or unknown pulse. The parser drops malformed frames, frames that overflow the RAM, and escape pairs that the closing byte cuts short, and then it waits for the next opening byte.

Top module: `frame_cmd_parser`

## Requirements
- R1: Outside a frame, every byte other than 0x02 is ignored: no RAM write, no length change and no command pulse follows it.
- R2: Inside a frame, the pair 0x1B,0xE7 restores to 0x02, the pair 0x1B,0xE8 restores to 0x03, and the pair 0x1B,0x00 restores to 0x1B. Each pair counts as one payload byte.
- R3: If 0x1B is followed by any byte other than 0xE7, 0xE8 or 0x00, the frame is dropped. This includes a closing 0x03 or an opening 0x02 in that position. A dropped frame leaves frame_len unchanged and raises no command pulse. The parser then waits for a fresh 0x02, and RAM writes already issued for that frame may remain.
- R4: An unescaped 0x02 inside a frame discards the bytes gathered so far and starts a new frame.
- R5: A frame of N >= 2 payload bytes produces exactly N RAM writes, to addresses 0 through N-1 in order, each carrying the restored byte. The last write is visible in the cycle after the closing byte's strobe.
- R6: After a data frame, frame_len shows N from the cycle after the closing byte's strobe. Command frames and empty frames leave frame_len unchanged.
- R7: A frame of exactly one payload byte makes no RAM write. The code 0x01 pulses cmd_start and the code 0x00 pulses cmd_stop. Any other code pulses cmd_unknown. Each pulse lasts one cycle and appears in the cycle after the closing byte's strobe.
- R8: An empty frame (0x02 followed directly by 0x03) has no effect at the outputs.
- R9: A frame that holds more than 2**AW restored bytes is dropped, and frame_len is unchanged. A frame of exactly 2**AW bytes is accepted.
- R10: After a closing byte, the next byte strobe is treated as header search. A 0x02 that follows the closing byte at once opens a new frame.
- R11: The parser moves only on a byte strobe. ram_we and the command pulses are high only in the cycle after a strobe.
- R12: While rst_n is low, ram_we, the command pulses and frame_len are zero, and the parser is in header search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| ram_we | output | 1 | Pattern RAM write enable |
| ram_addr | output | AW | Pattern RAM write address |
| ram_wdata | output | 8 | Pattern RAM write data (restored byte) |
| frame_len | output | AW+1 | Byte count of the last accepted data frame |
| cmd_start | output | 1 | One-cycle start command pulse |
| cmd_stop | output | 1 | One-cycle stop command pulse |
| cmd_unknown | output | 1 | One-cycle pulse for an unrecognised command code |

## Verification
A wrong escape flag or frame state shows up in the next frame. It appears as a corrupted restored byte in the RAM image, a wrong frame_len, or a command pulse where none belongs. The closing byte exposes it at the latest, one cycle after its strobe. A payload counter that is off by one shows as a missing or duplicated write address, or as a command frame taken for a data frame. Random frames rich in the bytes 0x02, 0x03 and 0x1B are run against a bench model, along with directed cases for truncated escapes, restarts and the length cap. Together they aim to turn each such fault into a port-level mismatch within one frame.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
   localparam logic [7:0] FCP_SOF     = 8'h02;
   localparam logic [7:0] FCP_EOF     = 8'h03;
   localparam logic [7:0] FCP_ESC     = 8'h1B;
   localparam logic [7:0] FCP_ESC_SOF = 8'hE7;
   localparam logic [7:0] FCP_ESC_EOF = 8'hE8;
   localparam logic [7:0] FCP_ESC_ESC = 8'h00;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_BODY  = 2'd1,
      ST_PARSE = 2'd2
   } fcp_state_t;
endpackage

// File: rtl/fcp_unstuff.sv
module fcp_unstuff
   import fcp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   input  logic       in_body,
   output logic       ev_sof,
   output logic       ev_eof,
   output logic       ev_data,
   output logic       ev_bad,
   output logic [7:0] data_out
);
   logic esc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         esc_q <= 1'b0;
      else if (byte_vld)
         esc_q <= in_body && !esc_q && (byte_in == FCP_ESC);
   end

   always_comb begin
      ev_sof   = 1'b0;
      ev_eof   = 1'b0;
      ev_data  = 1'b0;
      ev_bad   = 1'b0;
      data_out = byte_in;
      if (byte_vld && in_body) begin
         if (esc_q) begin
            unique case (byte_in)
               FCP_ESC_SOF: begin ev_data = 1'b1; data_out = FCP_SOF; end
               FCP_ESC_EOF: begin ev_data = 1'b1; data_out = FCP_EOF; end
               FCP_ESC_ESC: begin ev_data = 1'b1; data_out = FCP_ESC; end
               default:     ev_bad = 1'b1;
            endcase
         end else begin
            unique case (byte_in)
               FCP_SOF: ev_sof  = 1'b1;
               FCP_EOF: ev_eof  = 1'b1;
               FCP_ESC: ev_data = 1'b0;
               default: ev_data = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/fcp_writer.sv
module fcp_writer #(
   parameter int AW = 8,
   localparam int LW = AW + 1,
   localparam int MAXN = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [7:0]    push_byte,
   input  logic          finish,
   output logic          full,
   output logic          one_byte,
   output logic [7:0]    held,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   output logic [LW-1:0] frame_len
);
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] cnt_m1;

   assign full     = (cnt_q == LW'(MAXN));
   assign one_byte = (cnt_q == LW'(1));
   assign cnt_m1   = cnt_q - LW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         held      <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
         frame_len <= '0;
      end else begin
         ram_we <= 1'b0;
         if (clr) begin
            cnt_q <= '0;
         end else if (push) begin
            if (cnt_q != '0) begin
               ram_we    <= 1'b1;
               ram_addr  <= cnt_m1[AW-1:0];
               ram_wdata <= held;
            end
            held  <= push_byte;
            cnt_q <= cnt_q + LW'(1);
         end else if (finish && (cnt_q > LW'(1))) begin
            ram_we    <= 1'b1;
            ram_addr  <= cnt_m1[AW-1:0];
            ram_wdata <= held;
            frame_len <= cnt_q;
         end
      end
   end
endmodule

// File: rtl/fcp_cmd_decode.sv
module fcp_cmd_decode #(
   parameter logic [7:0] START_CODE = 8'h01,
   parameter logic [7:0] STOP_CODE  = 8'h00,
   parameter bit         FLAG_UNKNOWN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic [7:0] code,
   output logic       start_p,
   output logic       stop_p,
   output logic       unknown_p
);
   logic hit_start, hit_stop;

   assign hit_start = (code == START_CODE);
   assign hit_stop  = (code == STOP_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_p <= 1'b0;
         stop_p  <= 1'b0;
      end else begin
         start_p <= fire && hit_start;
         stop_p  <= fire && hit_stop;
      end
   end

   generate
      if (FLAG_UNKNOWN) begin : g_unknown
         always_ff @(posedge clk) begin
            if (!rst_n)
               unknown_p <= 1'b0;
            else
               unknown_p <= fire && !hit_start && !hit_stop;
         end
      end else begin : g_no_unknown
         assign unknown_p = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/frame_cmd_parser.sv
module frame_cmd_parser
   import fcp_pkg::*;
#(
   parameter int         AW = 8,
   parameter logic [7:0] START_CODE = 8'h01,
   parameter logic [7:0] STOP_CODE  = 8'h00,
   parameter bit         FLAG_UNKNOWN = 1'b1,
   localparam int        LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   output logic [LW-1:0] frame_len,
   output logic          cmd_start,
   output logic          cmd_stop,
   output logic          cmd_unknown
);
   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("frame_cmd_parser: AW must lie in 1..16");
      end
      if (START_CODE == STOP_CODE) begin : g_bad_codes
         $error("frame_cmd_parser: start and stop codes must differ");
      end
   endgenerate

   fcp_state_t state_q, state_d;
   logic       in_body;
   logic       ev_sof, ev_eof, ev_data, ev_bad;
   logic [7:0] dec_byte;
   logic       hunt_sof, w_full, w_one, push, open_frame, cmd_fire;
   logic [7:0] w_held;

   assign in_body  = (state_q == ST_BODY);
   assign hunt_sof = rx_valid && !in_body && (rx_byte == FCP_SOF);

   fcp_unstuff u_unstuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (rx_valid),
      .byte_in  (rx_byte),
      .in_body  (in_body),
      .ev_sof   (ev_sof),
      .ev_eof   (ev_eof),
      .ev_data  (ev_data),
      .ev_bad   (ev_bad),
      .data_out (dec_byte)
   );

   assign open_frame = hunt_sof || ev_sof;
   assign push       = ev_data && !w_full;
   assign cmd_fire   = ev_eof && w_one;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HUNT, ST_PARSE: begin
            if (rx_valid) state_d = hunt_sof ? ST_BODY : ST_HUNT;
         end
         ST_BODY: begin
            if (ev_bad || (ev_data && w_full)) state_d = ST_HUNT;
            else if (ev_eof)                   state_d = ST_PARSE;
         end
         default: state_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_HUNT;
      else        state_q <= state_d;
   end

   fcp_writer #(.AW(AW)) u_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (open_frame),
      .push      (push),
      .push_byte (dec_byte),
      .finish    (ev_eof),
      .full      (w_full),
      .one_byte  (w_one),
      .held      (w_held),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .frame_len (frame_len)
   );

   fcp_cmd_decode #(
      .START_CODE   (START_CODE),
      .STOP_CODE    (STOP_CODE),
      .FLAG_UNKNOWN (FLAG_UNKNOWN)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (cmd_fire),
      .code      (w_held),
      .start_p   (cmd_start),
      .stop_p    (cmd_stop),
      .unknown_p (cmd_unknown)
   );
endmodule

// File: rtl/fcp_checks.sv
module fcp_checks #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic [7:0]    rx_byte,
   input logic          ram_we,
   input logic [AW-1:0] ram_addr,
   input logic [AW:0]   frame_len,
   input logic          cmd_start,
   input logic          cmd_stop,
   input logic          cmd_unknown
);
   logic [AW:0] next_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      next_addr_q <= '0;
      else if (ram_we) next_addr_q <= {1'b0, ram_addr} + 1'b1;
   end

   // R7: at most one command pulse at a time
   a_r7_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_start, cmd_stop, cmd_unknown}));

   // R7: a command pulse follows a closing byte strobe
   a_r7_cmd_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start || cmd_stop || cmd_unknown) |-> ($past(rx_valid) && $past(rx_byte) == 8'h03));

   // R11: outputs pulse only in the cycle after a byte strobe
   a_r11_pulse_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || cmd_start || cmd_stop || cmd_unknown) |-> $past(rx_valid));

   // R6: frame_len moves only after a closing byte strobe
   a_r6_len_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_len) |-> ($past(rx_valid) && $past(rx_byte) == 8'h03));

   // R5: non-zero write addresses continue from the previous write
   a_r5_addr_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && ram_addr != '0) |-> ({1'b0, ram_addr} == next_addr_q));
endmodule

bind frame_cmd_parser fcp_checks #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_valid    (rx_valid),
   .rx_byte     (rx_byte),
   .ram_we      (ram_we),
   .ram_addr    (ram_addr),
   .frame_len   (frame_len),
   .cmd_start   (cmd_start),
   .cmd_stop    (cmd_stop),
   .cmd_unknown (cmd_unknown)
);

// File: tb/sim_frame_cmd_parser.sv
module sim_frame_cmd_parser;
   localparam int AW   = 8;
   localparam int MAXN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_byte = 8'h00;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;
   logic [AW:0]   frame_len;
   logic          cmd_start, cmd_stop, cmd_unknown;

   always #10 clk = ~clk;

   frame_cmd_parser #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .frame_len(frame_len), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_unknown(cmd_unknown)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] mem [0:MAXN-1];
   logic [7:0] pl  [0:MAXN+4];
   int pl_n;
   int wr_cnt, order_bad, n_start, n_stop, n_unk;
   int exp_len = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            if (int'(ram_addr) != wr_cnt) order_bad++;
            mem[ram_addr] = ram_wdata;
            wr_cnt++;
         end
         if (cmd_start)   n_start++;
         if (cmd_stop)    n_stop++;
         if (cmd_unknown) n_unk++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_obs();
      wr_cnt = 0; order_bad = 0; n_start = 0; n_stop = 0; n_unk = 0;
   endtask

   task automatic raw(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_byte = $urandom_range(0, 255);
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic send_stuffed(input logic [7:0] b);
      if (b == 8'h02)      begin raw(8'h1B); raw(8'hE7); end
      else if (b == 8'h03) begin raw(8'h1B); raw(8'hE8); end
      else if (b == 8'h1B) begin raw(8'h1B); raw(8'h00); end
      else raw(b);
   endtask

   task automatic send_frame();
      raw(8'h02);
      for (int i = 0; i < pl_n; i++) send_stuffed(pl[i]);
      raw(8'h03);
      repeat (2) @(negedge clk);
   endtask

   function automatic int code_kind(input logic [7:0] c);
      return (c == 8'h01) ? 1 : (c == 8'h00) ? 2 : 3;
   endfunction

   task automatic expect_frame();
      int mism = 0;
      if (pl_n >= 2) begin
         for (int i = 0; i < pl_n; i++) if (mem[i] != pl[i]) mism++;
         exp_len = pl_n;
         chk("R5 write count", wr_cnt, pl_n);
         chk("R5 write order", order_bad, 0);
         chk("R2 R5 restored data", mism, 0);
         chk("R6 frame_len", int'(frame_len), exp_len);
         chk("R7 no cmd on data frame", n_start + n_stop + n_unk, 0);
      end else if (pl_n == 1) begin
         chk("R7 no write on cmd frame", wr_cnt, 0);
         chk("R7 start count", n_start, code_kind(pl[0]) == 1 ? 1 : 0);
         chk("R7 stop count", n_stop, code_kind(pl[0]) == 2 ? 1 : 0);
         chk("R7 unknown count", n_unk, code_kind(pl[0]) == 3 ? 1 : 0);
         chk("R6 len kept on cmd", int'(frame_len), exp_len);
      end else begin
         chk("R8 empty no write", wr_cnt, 0);
         chk("R8 empty no cmd", n_start + n_stop + n_unk, 0);
         chk("R8 empty len kept", int'(frame_len), exp_len);
      end
   endtask

   function automatic logic [7:0] rand_byte();
      if ($urandom_range(0, 3) == 0) begin
         case ($urandom_range(0, 2))
            0: return 8'h02;
            1: return 8'h03;
            default: return 8'h1B;
         endcase
      end
      return 8'($urandom_range(0, 255));
   endfunction

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R12 ram_we in reset", int'(ram_we), 0);
      chk("R12 len in reset", int'(frame_len), 0);
      chk("R12 cmd in reset", int'({cmd_start, cmd_stop, cmd_unknown}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      clear_obs();

      // R1: stray bytes outside a frame
      raw(8'h03); raw(8'h1B); raw(8'h01); raw(8'h03); raw(8'h55);
      repeat (2) @(negedge clk);
      chk("R1 no write from noise", wr_cnt, 0);
      chk("R1 no cmd from noise", n_start + n_stop + n_unk, 0);

      // R11: byte values without a strobe are ignored
      @(negedge clk); rx_byte = 8'h02; repeat (4) @(negedge clk);
      rx_byte = 8'h01; repeat (2) @(negedge clk);
      raw(8'h03); repeat (2) @(negedge clk);
      chk("R11 no strobe no cmd", n_start, 0);

      // R2: every escaped value restored
      clear_obs();
      pl_n = 5; pl[0] = 8'h02; pl[1] = 8'h03; pl[2] = 8'h1B; pl[3] = 8'h41; pl[4] = 8'h00;
      send_frame(); expect_frame();

      // R3: bad escape drops the frame, parser back to header search
      clear_obs();
      raw(8'h02); raw(8'h41); raw(8'h42); raw(8'h1B); raw(8'h55); raw(8'h01); raw(8'h03);
      repeat (2) @(negedge clk);
      chk("R3 len kept after bad escape", int'(frame_len), exp_len);
      chk("R3 no cmd after bad escape", n_start + n_stop + n_unk, 0);
      clear_obs();
      raw(8'h02); raw(8'h01); raw(8'h1B); raw(8'h03); raw(8'h01); raw(8'h03);
      repeat (2) @(negedge clk);
      chk("R3 truncated escape no cmd", n_start + n_stop + n_unk, 0);
      chk("R3 truncated escape len kept", int'(frame_len), exp_len);

      // R4: unescaped header restarts the frame
      clear_obs();
      raw(8'h02); raw(8'h41); raw(8'h42); raw(8'h02); raw(8'h00); raw(8'h03);
      repeat (2) @(negedge clk);
      chk("R4 restart gives stop cmd", n_stop, 1);
      chk("R4 restart len kept", int'(frame_len), exp_len);

      // R7 R11: command pulse timing
      clear_obs();
      raw(8'h02); raw(8'h01);
      @(negedge clk); rx_byte = 8'h03; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      chk("R7 R11 start high after tail", int'(cmd_start), 1);
      @(negedge clk);
      chk("R7 R11 start one cycle", int'(cmd_start), 0);

      // R10: header right after tail
      clear_obs();
      raw(8'h02); raw(8'h61); raw(8'h62); raw(8'h03); raw(8'h02); raw(8'h77); raw(8'h03);
      repeat (2) @(negedge clk);
      exp_len = 2;
      chk("R10 first frame len", int'(frame_len), 2);
      chk("R10 second frame unknown", n_unk, 1);
      chk("R10 writes", wr_cnt, 2);

      // R8: empty frame
      clear_obs(); pl_n = 0; send_frame(); expect_frame();

      // R9: overflow and exact capacity
      clear_obs(); pl_n = MAXN + 1;
      for (int i = 0; i < pl_n; i++) pl[i] = 8'(i * 7 + 3);
      send_frame();
      chk("R9 overflow len kept", int'(frame_len), exp_len);
      chk("R9 overflow no cmd", n_start + n_stop + n_unk, 0);
      clear_obs(); pl_n = MAXN;
      for (int i = 0; i < pl_n; i++) pl[i] = 8'(i * 5 + 1);
      send_frame(); expect_frame();

      // Random frames
      for (int f = 0; f < 40; f++) begin
         int k = $urandom_range(0, 9);
         clear_obs();
         repeat ($urandom_range(0, 3)) begin
            logic [7:0] nb = rand_byte();
            if (nb != 8'h02) raw(nb);
         end
         if (k == 0) pl_n = 0;
         else if (k <= 3) pl_n = 1;
         else pl_n = $urandom_range(2, 24);
         for (int i = 0; i < pl_n; i++) pl[i] = rand_byte();
         if (pl_n == 1 && k == 1) pl[0] = 8'h01;
         if (pl_n == 1 && k == 2) pl[0] = 8'h00;
         send_frame(); expect_frame();
      end

      // R12: reset clears frame_len
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R12 len cleared by reset", int'(frame_len), 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule